// File: doc/BRIEF.md
# Cascadable BCD Decade Counter

This block is a four-bit synchronous counter that steps through the decimal digits 0 to 9 on rising clock edges. Every state bit changes on the same edge, so the outputs never pass through intermediate codes. A parallel preset copies a four-bit data word into the count on the next edge. Two count enables are provided: a parallel enable that only gates counting, and a trickle enable that gates both counting and the carry output. This lets several digits be chained into a multi-digit decimal counter. The carry of one digit feeds the trickle enable of the next, and every digit shares one parallel enable.

The clear input is active low. A parameter chooses whether it acts at once, independent of the clock, or on the next rising edge. Clear beats preset, and preset beats counting. If a non-decimal code from 10 to 15 is preset, the next enabled edge forces the count back to 0.

Top module: `bcd_decade_counter`

## Requirements
- R1: While clear_n is low, the count reads 0 no later than the first rising edge, and the carry output is low.
- R2: Clear takes priority: with clear_n low, a low load_n and high enables have no effect, and the count is 0 after the edge.
- R3: With clear_n high and load_n low, the rising edge copies data_in into the count whatever the levels of both enables.
- R4: With clear_n and load_n high and both enables high, a count of 0 to 8 increases by exactly 1 on each rising edge.
- R5: With both enables high and no load or clear, a count of 9 becomes 0 on the next rising edge.
- R6: With clear_n and load_n high and either enable low, the count keeps its value across the edge, including a non-decimal value.
- R7: carry_out is high exactly when the count equals 9 and en_trickle is high. It follows en_trickle without a clock edge and ignores en_parallel.
- R8: A count of 10 to 15 becomes 0 on the next rising edge that has both enables high and no load or clear.
- R9: With ASYNC_CLEAR = 1, a falling clear_n zeroes the count before the next clock edge. With ASYNC_CLEAR = 0, the count keeps its value until that edge and then becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear, asynchronous or synchronous per ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous preset |
| data_in | input | 4 | Preset value |
| en_parallel | input | 1 | Count enable that does not gate the carry |
| en_trickle | input | 1 | Count enable that also gates the carry |
| count | output | 4 | Current BCD digit |
| carry_out | output | 1 | High at count 9 with en_trickle high |

## Verification
Count, load and synchronous clear results appear one register after their stimulus. The bench drives inputs on the falling edge and compares both variants 1 ns after the next rising edge. carry_out has no register in its path, so it is checked in the same window against the newly expected count, and again within the same cycle after en_trickle alone changes. The asynchronous clear is due at once. Right after clear_n falls and before any edge, the bench expects the asynchronous instance to read 0 and the synchronous one to still hold its old value.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
    localparam int CNT_W     = 4;
    localparam int DIGIT_TOP = 9;
    localparam logic [CNT_W-1:0] TOP_CODE = CNT_W'(DIGIT_TOP);
    localparam logic [CNT_W-1:0] ZERO     = '0;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;
endpackage

// File: rtl/bcd_ctr_op_sel.sv
module bcd_ctr_op_sel
    import bcd_ctr_pkg::*;
#(
    parameter bit SYNC_CLEAR = 1'b0
) (
    input  logic    clear_n,
    input  logic    load_n,
    input  logic    en_parallel,
    input  logic    en_trickle,
    output ctr_op_e op
);
    logic clr_req;

    generate
        if (SYNC_CLEAR) begin : g_sync
            assign clr_req = ~clear_n;
        end else begin : g_async
            // the register clears itself; the synchronous path never sees it
            assign clr_req = 1'b0 & ~clear_n;
        end
    endgenerate

    always_comb begin
        if (clr_req)                       op = OP_CLEAR;
        else if (!load_n)                  op = OP_LOAD;
        else if (en_parallel && en_trickle) op = OP_COUNT;
        else                               op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_ctr_next.sv
module bcd_ctr_next
    import bcd_ctr_pkg::*;
(
    input  ctr_op_e          op,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] data_in,
    output logic [CNT_W-1:0] cnt_d
);
    logic at_or_past_top;

    // 9 wraps, and any code above 9 falls back to 0 as well
    assign at_or_past_top = (cnt_q >= TOP_CODE);

    always_comb begin
        unique case (op)
            OP_CLEAR: cnt_d = ZERO;
            OP_LOAD:  cnt_d = data_in;
            OP_COUNT: cnt_d = at_or_past_top ? ZERO : cnt_q + ONE;
            default:  cnt_d = cnt_q;
        endcase
    end
endmodule

// File: rtl/bcd_ctr_carry.sv
module bcd_ctr_carry
    import bcd_ctr_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             en_trickle,
    output logic             carry_out
);
    always_comb carry_out = en_trickle && (cnt_q == TOP_CODE);
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_ctr_pkg::*;
#(
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic [CNT_W-1:0] data_in,
    input  logic             en_parallel,
    input  logic             en_trickle,
    output logic [CNT_W-1:0] count,
    output logic             carry_out
);
    localparam bit SYNC_CLEAR = !ASYNC_CLEAR;

    ctr_op_e    op;
    ctr_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_nxt;

    bcd_ctr_op_sel #(.SYNC_CLEAR(SYNC_CLEAR)) op_sel_i (
        .clear_n     (clear_n),
        .load_n      (load_n),
        .en_parallel (en_parallel),
        .en_trickle  (en_trickle),
        .op          (op)
    );

    bcd_ctr_next next_i (
        .op      (op),
        .cnt_q   (st_q.cnt),
        .data_in (data_in),
        .cnt_d   (cnt_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
    end

    generate
        if (ASYNC_CLEAR) begin : g_areg
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) st_q <= '0;
                else          st_q <= st_d;
            end
        end else begin : g_sreg
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    bcd_ctr_carry carry_i (
        .cnt_q      (st_q.cnt),
        .en_trickle (en_trickle),
        .carry_out  (carry_out)
    );

    assign count = st_q.cnt;
endmodule

// File: rtl/bcd_ctr_chk.sv
module bcd_ctr_chk
    import bcd_ctr_pkg::*;
#(
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input logic             clk,
    input logic             clear_n,
    input logic             load_n,
    input logic [CNT_W-1:0] data_in,
    input logic             en_parallel,
    input logic             en_trickle,
    input logic [CNT_W-1:0] count,
    input logic             carry_out
);
    logic cnt_en;
    assign cnt_en = load_n && en_parallel && en_trickle;

    a_r1_clear_held: assert property (@(posedge clk)
        !clear_n ##1 !clear_n |-> (count == ZERO && !carry_out));

    generate
        if (!ASYNC_CLEAR) begin : g_sync_chk
            a_r9_sync_clear: assert property (@(posedge clk)
                !clear_n |=> count == ZERO);
        end
    endgenerate

    a_r3_load: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> count == $past(data_in));

    a_r4_increment: assert property (@(posedge clk) disable iff (!clear_n)
        cnt_en && count < TOP_CODE |=> count == $past(count) + ONE);

    a_r5_wrap: assert property (@(posedge clk) disable iff (!clear_n)
        cnt_en && count == TOP_CODE |=> count == ZERO);

    a_r6_hold: assert property (@(posedge clk) disable iff (!clear_n)
        load_n && !(en_parallel && en_trickle) |=> $stable(count));

    a_r7_carry_gate: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out |-> (en_trickle && count == TOP_CODE));

    a_r8_illegal_recover: assert property (@(posedge clk) disable iff (!clear_n)
        cnt_en && count > TOP_CODE |=> count == ZERO);
endmodule

bind bcd_decade_counter bcd_ctr_chk #(.ASYNC_CLEAR(ASYNC_CLEAR)) chk_i (
    .clk         (clk),
    .clear_n     (clear_n),
    .load_n      (load_n),
    .data_in     (data_in),
    .en_parallel (en_parallel),
    .en_trickle  (en_trickle),
    .count       (count),
    .carry_out   (carry_out)
);

// File: tb/bcd_decade_counter_tb.sv
`timescale 1ns/1ps
module bcd_decade_counter_tb_top;
    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] data_in = 4'd0;
    logic       en_parallel = 1'b0;
    logic       en_trickle = 1'b0;
    logic [3:0] q_a, q_s;
    logic       c_a, c_s;

    int n_vec = 0;
    int n_bad = 0;
    int m_a = 0;
    int m_s = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bcd_decade_counter #(.ASYNC_CLEAR(1'b1)) dut_i (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .data_in(data_in),
        .en_parallel(en_parallel), .en_trickle(en_trickle),
        .count(q_a), .carry_out(c_a));

    bcd_decade_counter #(.ASYNC_CLEAR(1'b0)) dut_s (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .data_in(data_in),
        .en_parallel(en_parallel), .en_trickle(en_trickle),
        .count(q_s), .carry_out(c_s));

    function automatic int ref_next(int cur, bit cl, bit ld, bit ep, bit et, int d);
        if (!cl)           return 0;
        if (!ld)           return d;
        if (ep && et)      return (cur >= 9) ? 0 : cur + 1;
        return cur;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outs(string tag);
        chk({tag, " async count"}, int'(q_a), m_a);
        chk({tag, " sync count"},  int'(q_s), m_s);
        chk({tag, " async carry R7"}, int'(c_a), (m_a == 9 && en_trickle) ? 1 : 0);
        chk({tag, " sync carry R7"},  int'(c_s), (m_s == 9 && en_trickle) ? 1 : 0);
    endtask

    task automatic apply(string tag, bit cl, bit ld, bit ep, bit et, int d);
        @(negedge clk);
        clear_n = cl; load_n = ld; en_parallel = ep; en_trickle = et;
        data_in = 4'(d);
        if (!cl) begin
            #1;
            chk({tag, " R9 async clear before edge"}, int'(q_a), 0);
            chk({tag, " R9 sync waits for edge"}, int'(q_s), m_s);
            m_a = 0;
        end
        m_a = cl ? ref_next(m_a, cl, ld, ep, et, d) : 0;
        m_s = ref_next(m_s, cl, ld, ep, et, d);
        @(posedge clk);
        #1;
        check_outs(tag);
    endtask

    initial begin
        #(8 * 5000);
        if (!finished) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        apply("R1 reset", 0, 1, 0, 0, 0);
        apply("R1 reset held", 0, 1, 1, 1, 0);
        // R4/R5: straight counting through a wrap
        for (int i = 0; i < 12; i++) apply("R4 R5 count", 1, 1, 1, 1, 0);
        // stop at 9 to look at carry gating
        for (int i = 0; i < 7; i++) apply("R4 count to 9", 1, 1, 1, 1, 0);
        apply("R6 hold ep low at 9", 1, 1, 0, 1, 0);
        apply("R7 carry with et low", 1, 1, 1, 0, 0);
        // R7: carry follows en_trickle without an edge
        @(negedge clk);
        en_trickle = 1'b1; en_parallel = 1'b0;
        #1;
        chk("R7 carry rises combinationally", int'(c_a), (m_a == 9) ? 1 : 0);
        en_trickle = 1'b0;
        #1;
        chk("R7 carry drops combinationally", int'(c_a), 0);
        apply("R5 wrap", 1, 1, 1, 1, 0);
        // R3: load ignores enables
        apply("R3 load 7 enables low", 1, 0, 0, 0, 7);
        apply("R3 load 2 enables high", 1, 0, 1, 1, 2);
        apply("R6 hold et low", 1, 1, 1, 0, 0);
        // R2: clear beats load
        apply("R2 clear over load", 0, 0, 1, 1, 5);
        apply("R3 load 9", 1, 0, 0, 1, 9);
        // R8: illegal codes
        apply("R8 load 12", 1, 0, 0, 0, 12);
        apply("R6 hold illegal", 1, 1, 0, 1, 0);
        apply("R8 recover from 12", 1, 1, 1, 1, 0);
        apply("R8 load 15", 1, 0, 1, 1, 15);
        apply("R8 recover from 15", 1, 1, 1, 1, 0);
        apply("R8 load 10", 1, 0, 1, 1, 10);
        apply("R8 recover from 10", 1, 1, 1, 1, 0);
        // R9: clear arriving mid-count
        for (int i = 0; i < 4; i++) apply("R4 count", 1, 1, 1, 1, 0);
        apply("R9 clear mid count", 0, 1, 1, 1, 0);
        apply("R1 release", 1, 1, 1, 1, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule